// File: doc/BRIEF.md
# Dual-Channel Multiplexed Output Formatter

This block receives a pair of conversion words, one for lane A and one for lane B, taken at the same rising clock edge. It delays the pair through a fixed pipeline and then time-shares a single output bus between the two lanes. The lane A word drives the bus during the high half of the clock and the lane B word during the low half. A lane flag, high while lane A is shown and low while lane B is shown, lets a receiver that only has the bus and the flag tell the two lanes apart.

Input words are offset binary. A format-select pin can convert both words of a pair to two's complement, and an output-enable pin controls a drive-enable output for an external three-state pad. The input side is a stream with a valid strobe only. The block takes a pair on every rising edge where the strobe is high and never applies back-pressure, so there is no ready signal. When the strobe is low the bus keeps repeating the last pair it showed.

Top module: `dual_lane_bus_mux`

## Requirements
- R1: When `pair_valid` is high at a rising edge, `a_word` and `b_word` are both captured at that edge. A pair is accepted on every such edge, with no back-pressure.
- R2: A pair captured at rising edge k puts its lane A word on `bus_word` from rising edge k+LAT (LAT = 5) until the next falling edge.
- R3: The lane B word of that pair drives `bus_word` from the falling edge that follows, which is LAT + 0.5 cycles after capture, until the next rising edge.
- R4: Once the first pair has reached the output, `lane_is_a` is 1 in every high clock phase and 0 in every low clock phase.
- R5: `twos_sel` is sampled at the rising edge where a pair's lane A word is loaded, and it applies to both words of that pair. With 0 the words pass unchanged. With 1 bit 9 (the MSB) is inverted and bits 8:0 are unchanged, which gives two's complement.
- R6: After reset, `bus_word` is 0 and `lane_is_a` is 0 in both clock phases until the first valid pair reaches the output.
- R7: `bus_drive` is reset to 0. It takes the value of `out_en` at each rising edge and holds it through both halves of that cycle. A change of `out_en` between rising edges has no effect until the next rising edge.
- R8: When no valid pair arrives at the output for a cycle, the bus repeats the previous pair with its previous coding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Both edges are used. |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_word | input | 10 | Lane A sample, offset binary |
| b_word | input | 10 | Lane B sample, offset binary |
| pair_valid | input | 1 | Valid strobe for the sample pair |
| twos_sel | input | 1 | 1 selects two's complement output coding |
| out_en | input | 1 | Request to drive the output bus |
| bus_word | output | 10 | Shared data bus, lane A in the high phase, lane B in the low phase |
| lane_is_a | output | 1 | High while lane A data is on the bus |
| bus_drive | output | 1 | Enable for the external three-state driver |

## Verification
A wrong latency count shows as a lane word at the port one or more cycles early or late. It is visible in the first half-cycle where the pair should appear. A phase flag that falls out of step with the clock swaps the lanes on the bus and inverts `lane_is_a` within one edge. A format or enable sampled at the wrong edge corrupts only the MSB, or the drive enable, of the pair that straddles the change. For that reason the stimulus toggles both controls often and moves `out_en` in the middle of a cycle.

// File: rtl/dual_lane_pkg.sv
`timescale 1ns/1ps
package dual_lane_pkg;
  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } code_fmt_e;
endpackage

// File: rtl/pair_delay.sv
`timescale 1ns/1ps
module pair_delay #(
  parameter int W     = 10,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0]        vld;
  logic [DEPTH-1:0][W-1:0] sa;
  logic [DEPTH-1:0][W-1:0] sb;

  // stage 0 is the capture register; both lanes are taken at the same edge
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[0] <= 1'b0;
          sa[0]  <= '0;
          sb[0]  <= '0;
        end else begin
          vld[0] <= in_valid;
          sa[0]  <= in_a;
          sb[0]  <= in_b;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[i] <= 1'b0;
          sa[i]  <= '0;
          sb[i]  <= '0;
        end else begin
          vld[i] <= vld[i-1];
          sa[i]  <= sa[i-1];
          sb[i]  <= sb[i-1];
        end
      end
    end
  end

  assign out_valid = vld[LAST];
  assign out_a     = sa[LAST];
  assign out_b     = sb[LAST];
endmodule

// File: rtl/word_coder.sv
`timescale 1ns/1ps
module word_coder
  import dual_lane_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] raw,
  input  code_fmt_e    mode,
  output logic [W-1:0] coded
);
  localparam int MSB = W - 1;

  always_comb begin
    coded      = raw;
    coded[MSB] = raw[MSB] ^ (mode == FMT_TWOS);
  end
endmodule

// File: rtl/dual_edge_bus.sv
`timescale 1ns/1ps
module dual_edge_bus #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         oe_in,
  output logic [W-1:0] bus_word,
  output logic         lane_is_a,
  output logic         bus_drive
);
  logic [W-1:0] a_q, b_hold, b_q;
  logic         live, oe_q;
  logic         rise_ph, fall_ph;

  // rising-edge side: lane A word, staged lane B word, format and enable together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_hold  <= '0;
      live    <= 1'b0;
      oe_q    <= 1'b0;
      rise_ph <= 1'b0;
    end else begin
      rise_ph <= ~rise_ph;
      oe_q    <= oe_in;
      if (load) begin
        a_q    <= a_in;
        b_hold <= b_in;
        live   <= 1'b1;
      end
    end
  end

  // falling-edge side: lane B word moves out half a cycle later
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q     <= '0;
      fall_ph <= 1'b0;
    end else begin
      b_q     <= b_hold;
      fall_ph <= rise_ph;
    end
  end

  // phases differ after a rising edge and agree after a falling edge
  logic high_phase;
  assign high_phase = rise_ph ^ fall_ph;
  assign lane_is_a  = live & high_phase;
  assign bus_word   = high_phase ? a_q : b_q;
  assign bus_drive  = oe_q;

  // R4: flag is low just before each rising edge
  p_lane_low_before_rise_r4 : assert property (
    @(posedge clk) disable iff (!rst_n) !lane_is_a
  );
  // R4: flag is high just before each falling edge once data flows
  p_lane_high_before_fall_r4 : assert property (
    @(negedge clk) disable iff (!rst_n) live |-> lane_is_a
  );
  // R6: idle outputs stay zero until the first pair arrives
  p_idle_outputs_zero_r6 : assert property (
    @(negedge clk) disable iff (!rst_n) !live |-> (bus_word == '0 && !lane_is_a)
  );
  // R6: once data has appeared the block never returns to the idle state
  p_live_sticky_r6 : assert property (
    @(posedge clk) disable iff (!rst_n) live |=> live
  );
endmodule

// File: rtl/dual_lane_bus_mux.sv
`timescale 1ns/1ps
module dual_lane_bus_mux
  import dual_lane_pkg::*;
#(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  input  logic         pair_valid,
  input  logic         twos_sel,
  input  logic         out_en,
  output logic [W-1:0] bus_word,
  output logic         lane_is_a,
  output logic         bus_drive
);
  // capture edge plus LAT-1 shift stages; the output stage adds the last cycle
  localparam int DEPTH = LAT;

  logic         d_valid;
  logic [W-1:0] d_a, d_b, c_a, c_b;
  code_fmt_e    mode;

  assign mode = code_fmt_e'(twos_sel);

  pair_delay #(.W(W), .DEPTH(DEPTH)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pair_valid),
    .in_a      (a_word),
    .in_b      (b_word),
    .out_valid (d_valid),
    .out_a     (d_a),
    .out_b     (d_b)
  );

  word_coder #(.W(W)) u_code_a (.raw(d_a), .mode(mode), .coded(c_a));
  word_coder #(.W(W)) u_code_b (.raw(d_b), .mode(mode), .coded(c_b));

  dual_edge_bus #(.W(W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (d_valid),
    .a_in      (c_a),
    .b_in      (c_b),
    .oe_in     (out_en),
    .bus_word  (bus_word),
    .lane_is_a (lane_is_a),
    .bus_drive (bus_drive)
  );
endmodule

// File: tb/tb_dual_lane_bus_mux.sv
`timescale 1ns/1ps
module tb_dual_lane_bus_mux;
  localparam int W    = 10;
  localparam int LAT  = 5;
  localparam int NMAX = 4096;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_word = '0, b_word = '0;
  logic         pair_valid = 1'b0, twos_sel = 1'b0, out_en = 1'b0;
  logic [W-1:0] bus_word;
  logic         lane_is_a, bus_drive;

  dual_lane_bus_mux #(.W(W), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .a_word(a_word), .b_word(b_word),
    .pair_valid(pair_valid), .twos_sel(twos_sel), .out_en(out_en),
    .bus_word(bus_word), .lane_is_a(lane_is_a), .bus_drive(bus_drive)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, m = 0;
  bit hv [NMAX];
  int ha [NMAX], hb [NMAX];
  int cur_a = 0, cur_b = 0, oe_exp = 0;
  bit live = 0, held = 0, cur_twos = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, m, act, exp);
    end
  endtask

  function automatic int cv(input int x, input bit tw);
    return tw ? (x ^ (1 << (W - 1))) : x;
  endfunction

  // one clock cycle: drive in the low phase, check in the high and low phases
  task automatic step(input bit v, input int a, input int b, input bit f,
                      input bit o, input bit glitch);
    string tg;
    pair_valid = v; a_word = W'(a); b_word = W'(b); twos_sel = f; out_en = o;
    hv[m] = v; ha[m] = a & MASK; hb[m] = b & MASK;
    @(posedge clk);
    oe_exp = o;
    if (m >= LAT && hv[m-LAT]) begin
      cur_a = cv(ha[m-LAT], f); cur_b = cv(hb[m-LAT], f);
      cur_twos = f; live = 1; held = 0;
    end else held = 1;
    #1;
    chk(bus_drive == oe_exp, "R7 high", bus_drive, oe_exp);
    if (!live) begin
      chk(bus_word == 0, "R6 bus high", bus_word, 0);
      chk(lane_is_a == 0, "R6 flag high", lane_is_a, 0);
    end else begin
      tg = {"R2", cur_twos ? " R5" : "", held ? " R8" : ""};
      chk(bus_word == cur_a, tg, bus_word, cur_a);
      chk(lane_is_a == 1, "R4 high", lane_is_a, 1);
    end
    if (glitch) out_en = ~o;  // R7: mid-cycle change must not show yet
    @(negedge clk);
    #1;
    chk(bus_drive == oe_exp, "R7 low", bus_drive, oe_exp);
    if (!live) begin
      chk(bus_word == 0, "R6 bus low", bus_word, 0);
      chk(lane_is_a == 0, "R6 flag low", lane_is_a, 0);
    end else begin
      tg = {"R1 R3", cur_twos ? " R5" : "", held ? " R8" : ""};
      chk(bus_word == cur_b, tg, bus_word, cur_b);
      chk(lane_is_a == 0, "R4 low", lane_is_a, 0);
    end
    m++;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(bus_word == 0, "R6 reset bus", bus_word, 0);
    chk(lane_is_a == 0, "R6 reset flag", lane_is_a, 0);
    chk(bus_drive == 0, "R7 reset drive", bus_drive, 0);
    rst_n = 1'b1;
    // idle cycles with junk data: bus must stay zero (R6)
    for (int i = 0; i < 8; i++) step(0, 300 + i, 700 - i, i[0], 1, 0);
    // full sweep of lane A codes, both formats, continuous valid (R1 R2 R3 R5)
    for (int i = 0; i < 1024; i++)
      step(1, i, (i * 37 + 5), i[1], (i % 7) != 0, 0);
    // gapped traffic with mid-cycle enable changes (R7 R8)
    for (int i = 0; i < 600; i++)
      step(((i * 5) % 3) != 0, (i * 131 + 17), (i * 59 + 900), (i / 3) % 2 == 1,
           (i % 4) < 2, 1);
    // flush: last pairs drain and then repeat (R8)
    for (int i = 0; i < LAT + 4; i++) step(0, 0, 0, 0, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule